// File: doc/BRIEF.md
# Dual-Mode LED Driver Configuration Loader

This block is the serial front end of a sixteen-channel LED current-sink driver. A host sends data on a clock/data pair and then pulses a latch strobe. A mode level picks the target. When the mode is low, one enable bit per channel goes into the on/off register. When the mode is high, a 7-bit brightness trim per channel goes into the correction register. Every serial input is brought into one system clock domain through synchronisers. Edges on the serial clock and on the latch strobe are found by edge detection, so neither input is ever used as a real clock.

The shifter is one chain of CHANNELS*CORR_W stages. The serial output taps either the short part of the chain (CHANNELS stages) or the whole chain, depending on the mode. This lets the serial output of one device feed the serial input of the next. After an on/off latch, the falling edge of the strobe reloads the low CHANNELS stages with the per-channel open-LED flags. The host then reads these flags back while it shifts in the next word.

A small state machine sequences the strobe. The state ST_IDLE waits for a latch rise. On a latch rise it goes to ST_HOLD_ONOFF if the mode is low, or to ST_HOLD_CORR if the mode is high. The on/off register is written only when blank is high. ST_HOLD_ONOFF returns to ST_IDLE on the latch fall and loads the fault flags into the shifter. ST_HOLD_CORR returns to ST_IDLE on the latch fall and leaves the shifter untouched.

Top module: `led_cfg_loader`

## Requirements
- R1: After reset, onoff_q, corr_q and the whole shifter are zero, so sdata_out is 0.
- R2: Each rising edge of sclk_in shifts sdata_in into chain bit 0, and every other bit moves up by one, so the first bit sent ends up highest. After an on/off latch, bit n of the last 16 bits shifted drives onoff_q[n] (channel n).
- R3: When mode_in is low, sdata_out equals the bit that was shifted in 16 serial clocks earlier.
- R4: When mode_in is high, sdata_out equals the bit that was shifted in 112 serial clocks earlier. Channel n's trim occupies corr_q[7n+6:7n] with its MSB sent first, so channel 15 is sent first.
- R5: A latch rise while mode_in is high copies the whole chain into corr_q and leaves onoff_q unchanged.
- R6: A latch rise while mode_in is low and blank_in is high copies the low 16 chain bits into onoff_q and leaves corr_q unchanged.
- R7: A latch rise while mode_in is low and blank_in is low leaves onoff_q unchanged.
- R8: The latch fall that follows an on/off latch overwrites the low 16 chain bits with open_flags, with flag n in bit n. The flags then appear on sdata_out with flag 15 first.
- R9: A change of mode_in does not alter the shifter. Only the tap that sdata_out reads changes.
- R10: The latch fall that follows a correction latch leaves the shifter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_in | input | 1 | Serial shift clock, sampled |
| sdata_in | input | 1 | Serial data in |
| mode_in | input | 1 | 0 = on/off word, 1 = correction word |
| latch_in | input | 1 | Latch strobe |
| blank_in | input | 1 | On/off latch permitted when high |
| open_flags | input | CHANNELS | Per-channel open-LED status |
| sdata_out | output | 1 | Serial data out (cascade / readback) |
| onoff_q | output | CHANNELS | Per-channel enable register |
| corr_q | output | CHANNELS*CORR_W | Per-channel brightness trim register |

## Verification
The hardest state to reach from the ports is the fault readback. The open-LED flags become visible only after a complete sequence: an on/off word is shifted in, it is latched with blank high, and the strobe falls. Only then does each further shift expose one flag on sdata_out. The bench drives that whole sequence and then shifts sixteen more bits, comparing each sampled output bit with the flag expected at that position. A mode flip with no latch shows that the chain is kept: after a 112-bit load, the output must show both bit 15 and bit 111 of the loaded word.

// File: rtl/led_cfg_pkg.sv
package led_cfg_pkg;
    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_HOLD_ONOFF = 2'd1,
        ST_HOLD_CORR  = 2'd2
    } ldr_state_t;
endpackage

// File: rtl/led_bit_sync.sv
module led_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o
);
    logic [STAGES-1:0] pipe;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= async_in;
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe <= '0;
                else        pipe <= {pipe[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign level_o = pipe[STAGES-1];
endmodule

// File: rtl/led_shift_chain.sv
module led_shift_chain #(
    parameter int SHORT_LEN = 16,
    parameter int LONG_LEN  = 112
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 shift_en,
    input  logic                 din,
    input  logic                 low_load,
    input  logic [SHORT_LEN-1:0] low_data,
    input  logic                 long_sel,
    output logic [LONG_LEN-1:0]  chain,
    output logic                 dout
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain <= '0;
        end else if (low_load) begin
            chain[SHORT_LEN-1:0] <= low_data;
        end else if (shift_en) begin
            chain <= {chain[LONG_LEN-2:0], din};
        end
    end

    assign dout = long_sel ? chain[LONG_LEN-1] : chain[SHORT_LEN-1];
endmodule

// File: rtl/led_cfg_loader.sv
module led_cfg_loader
    import led_cfg_pkg::*;
#(
    parameter int CHANNELS    = 16,
    parameter int CORR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sclk_in,
    input  logic                         sdata_in,
    input  logic                         mode_in,
    input  logic                         latch_in,
    input  logic                         blank_in,
    input  logic [CHANNELS-1:0]          open_flags,
    output logic                         sdata_out,
    output logic [CHANNELS-1:0]          onoff_q,
    output logic [CHANNELS*CORR_W-1:0]   corr_q
);
    localparam int LONG_LEN = CHANNELS * CORR_W;

    logic sclk_s, sdata_s, mode_s, latch_s, blank_s;
    logic sclk_prev, latch_prev;
    logic sclk_rise, latch_rise, latch_fall;
    logic load_onoff, load_corr, flag_load;
    logic [LONG_LEN-1:0] chain;
    ldr_state_t st_q, st_d;

    led_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_sclk  (.clk(clk), .rst_n(rst_n), .async_in(sclk_in),  .level_o(sclk_s));
    led_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_data  (.clk(clk), .rst_n(rst_n), .async_in(sdata_in), .level_o(sdata_s));
    led_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_mode  (.clk(clk), .rst_n(rst_n), .async_in(mode_in),  .level_o(mode_s));
    led_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_latch (.clk(clk), .rst_n(rst_n), .async_in(latch_in), .level_o(latch_s));
    led_bit_sync #(.STAGES(SYNC_STAGES)) u_sync_blank (.clk(clk), .rst_n(rst_n), .async_in(blank_in), .level_o(blank_s));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev  <= 1'b0;
            latch_prev <= 1'b0;
        end else begin
            sclk_prev  <= sclk_s;
            latch_prev <= latch_s;
        end
    end

    assign sclk_rise  = sclk_s & ~sclk_prev;
    assign latch_rise = latch_s & ~latch_prev;
    assign latch_fall = ~latch_s & latch_prev;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // next state and strobes
    always_comb begin
        st_d       = st_q;
        load_onoff = 1'b0;
        load_corr  = 1'b0;
        flag_load  = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (latch_rise) begin
                    if (mode_s) begin
                        load_corr = 1'b1;
                        st_d      = ST_HOLD_CORR;
                    end else begin
                        load_onoff = blank_s;
                        st_d       = ST_HOLD_ONOFF;
                    end
                end
            end
            ST_HOLD_ONOFF: begin
                if (latch_fall) begin
                    flag_load = 1'b1;
                    st_d      = ST_IDLE;
                end
            end
            ST_HOLD_CORR: begin
                if (latch_fall) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    led_shift_chain #(.SHORT_LEN(CHANNELS), .LONG_LEN(LONG_LEN)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sclk_rise),
        .din      (sdata_s),
        .low_load (flag_load),
        .low_data (open_flags),
        .long_sel (mode_s),
        .chain    (chain),
        .dout     (sdata_out)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            onoff_q <= '0;
            corr_q  <= '0;
        end else begin
            if (load_onoff) onoff_q <= chain[CHANNELS-1:0];
            if (load_corr)  corr_q  <= chain;
        end
    end
endmodule

// File: rtl/led_cfg_loader_chk.sv
module led_cfg_loader_chk #(
    parameter int CHANNELS = 16,
    parameter int CORR_W   = 7
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic [CHANNELS-1:0]         onoff_q,
    input logic [CHANNELS*CORR_W-1:0]  corr_q,
    input logic                        sdata_out,
    input logic [CHANNELS-1:0]         open_flags,
    input logic                        blank_s,
    input logic                        mode_s,
    input logic                        sclk_rise,
    input logic                        latch_rise,
    input logic                        flag_load,
    input logic [CHANNELS*CORR_W-1:0]  chain
);
    AST_ONOFF_ONLY_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(onoff_q) |-> $past(latch_rise && !mode_s && blank_s)); // R7

    AST_CORR_ONLY_ON_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(corr_q) |-> $past(latch_rise && mode_s)); // R5

    AST_SHORT_TAP_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && !mode_s && !flag_load) |=> (mode_s || sdata_out == $past(chain[CHANNELS-2]))); // R3

    AST_MODE_KEEPS_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_s != $past(mode_s)) && !$past(sclk_rise) && !$past(flag_load)) |-> $stable(chain)); // R9

    AST_FLAG_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        flag_load |=> chain[CHANNELS-1:0] == $past(open_flags)); // R8
endmodule

bind led_cfg_loader led_cfg_loader_chk #(.CHANNELS(CHANNELS), .CORR_W(CORR_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .onoff_q    (onoff_q),
    .corr_q     (corr_q),
    .sdata_out  (sdata_out),
    .open_flags (open_flags),
    .blank_s    (blank_s),
    .mode_s     (mode_s),
    .sclk_rise  (sclk_rise),
    .latch_rise (latch_rise),
    .flag_load  (flag_load),
    .chain      (chain)
);

// File: tb/led_cfg_loader_tb_top.sv
module led_cfg_loader_tb_top;
    localparam int CH = 16;
    localparam int CW = 7;
    localparam int LL = CH * CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_in = 1'b0, sdata_in = 1'b0, mode_in = 1'b0, latch_in = 1'b0, blank_in = 1'b0;
    logic [CH-1:0] open_flags = '0;
    logic sdata_out;
    logic [CH-1:0] onoff_q;
    logic [LL-1:0] corr_q;

    int checks = 0;
    int errs = 0;
    bit done = 0;

    always #2 clk = ~clk;

    led_cfg_loader #(.CHANNELS(CH), .CORR_W(CW), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_in(sclk_in), .sdata_in(sdata_in),
        .mode_in(mode_in), .latch_in(latch_in), .blank_in(blank_in),
        .open_flags(open_flags), .sdata_out(sdata_out),
        .onoff_q(onoff_q), .corr_q(corr_q)
    );

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input logic [LL-1:0] act, input logic [LL-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sdata_in = b;
        wait_clk(1);
        sclk_in = 1'b1;
        wait_clk(4);
        sclk_in = 1'b0;
        wait_clk(4);
    endtask

    task automatic pulse_latch();
        latch_in = 1'b1;
        wait_clk(5);
        latch_in = 1'b0;
        wait_clk(6);
    endtask

    task automatic set_mode(input logic m);
        mode_in = m;
        wait_clk(5);
    endtask

    function automatic logic [LL-1:0] corr_word(input int seed);
        logic [LL-1:0] w;
        for (int c = 0; c < CH; c++) w[c*CW +: CW] = 7'((c * 37 + seed * 11 + 5) & 127);
        return w;
    endfunction

    task automatic send_corr(input logic [LL-1:0] w);
        for (int b = LL - 1; b >= 0; b--) send_bit(w[b]);
    endtask

    task automatic send_onoff(input logic [CH-1:0] w);
        for (int b = CH - 1; b >= 0; b--) send_bit(w[b]);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        logic [CH-1:0] held;
        logic [LL-1:0] w, prev_corr;
        logic [CH-1:0] ow;
        wait_clk(3);
        rst_n = 1'b1;
        wait_clk(3);
        // R1 reset state
        chk(onoff_q == '0, "R1 onoff", LL'(onoff_q), '0);
        chk(corr_q == '0, "R1 corr", corr_q, '0);
        chk(sdata_out == 1'b0, "R1 sout", LL'(sdata_out), '0);

        // R2/R6 on/off load sweep with blank high, corr untouched
        blank_in = 1'b1;
        for (int k = 0; k < 8; k++) begin
            ow = (k == 0) ? 16'hFFFF : (k == 1) ? 16'h0001 : (k == 2) ? 16'h8000 :
                 16'((k * 16'h1357) ^ 16'hA5C3);
            send_onoff(ow);
            pulse_latch();
            chk(onoff_q == ow, "R2 R6 onoff load", LL'(onoff_q), LL'(ow));
            chk(corr_q == '0, "R6 corr unchanged", corr_q, '0);
        end

        // R7 blank low blocks on/off latch
        held = onoff_q;
        blank_in = 1'b0;
        send_onoff(~held);
        pulse_latch();
        chk(onoff_q == held, "R7 blank low ignored", LL'(onoff_q), LL'(held));
        blank_in = 1'b1;

        // R3 short chain cascade: previous word emerges MSB first
        open_flags = '0;
        send_onoff(16'hC3A5);
        for (int b = CH - 1; b >= 0; b--) begin
            ow = 16'hC3A5;
            chk(sdata_out == ow[b], "R3 short cascade", LL'(sdata_out), LL'(ow[b]));
            send_bit(1'b0);
        end

        // R8 fault flag readback
        open_flags = 16'hB2D1;
        send_onoff(16'h0F0F);
        pulse_latch();
        chk(onoff_q == 16'h0F0F, "R6 onoff before readback", LL'(onoff_q), LL'(16'h0F0F));
        for (int b = CH - 1; b >= 0; b--) begin
            ow = 16'hB2D1;
            chk(sdata_out == ow[b], "R8 flag readback", LL'(sdata_out), LL'(ow[b]));
            send_bit(1'b1);
        end

        // R4/R5 correction loads
        set_mode(1'b1);
        held = onoff_q;
        for (int s = 0; s < 3; s++) begin
            w = corr_word(s);
            send_corr(w);
            if (s == 2) open_flags = {~w[CH-1], 15'h1234};
            pulse_latch();
            for (int c = 0; c < CH; c++)
                chk(corr_q[c*CW +: CW] == w[c*CW +: CW], "R4 R5 channel trim",
                    LL'(corr_q[c*CW +: CW]), LL'(w[c*CW +: CW]));
            chk(onoff_q == held, "R5 onoff unchanged", LL'(onoff_q), LL'(held));
            // R10 chain unchanged after correction latch fall
            chk(sdata_out == w[LL-1], "R10 long tap after latch", LL'(sdata_out), LL'(w[LL-1]));
        end

        // R9 mode change keeps chain
        w = corr_word(2);
        set_mode(1'b0);
        chk(sdata_out == w[CH-1], "R9 R10 short tap after switch", LL'(sdata_out), LL'(w[CH-1]));
        set_mode(1'b1);
        chk(sdata_out == w[LL-1], "R9 long tap after switch back", LL'(sdata_out), LL'(w[LL-1]));

        // R4 long cascade: channel 15 trim emerges MSB first
        prev_corr = corr_q;
        for (int b = LL - 1; b >= LL - CW; b--) begin
            chk(sdata_out == w[b], "R4 long cascade", LL'(sdata_out), LL'(w[b]));
            send_bit(1'b0);
        end
        chk(corr_q == prev_corr, "R5 shifting alone keeps corr", corr_q, prev_corr);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule